// File: doc/BRIEF.md
# Safety Error Status Collector

This block gathers hardware safety events from three parts of a network controller and holds them for software. The three sources are the MAC (datapath parity and state-machine or bus timeouts), the ECC checks on the transmit/receive buffer memories, and the ECC check on the DMA segmentation memory. Each source raises single-cycle pulses on a 32-bit event vector. Every pulse on an implemented bit sets a sticky status bit. Software clears a status bit by writing a 1 to it, so writing back the value it just read clears exactly those bits.

A read-only summary word condenses the three status words into five flags: a MAC flag, correctable and uncorrectable flags for the buffer memories, and correctable and uncorrectable flags for the DMA memory. Uncorrectable events always raise the single interrupt line. A correctable event raises it only when the enable for its memory is set. A protection-level register decides which event groups are captured at all.

Register access uses a simple bus with select, write, word address and write data, and a combinational read. The word addresses are: 0 MAC status, 1 buffer ECC status, 2 DMA ECC status, 3 summary, 4 interrupt enables, 5 protection level.

Top module: `safety_err_collector`

## Requirements
- R1: After reset, all six registers read zero and `irq` is low.
- R2: A pulse on an implemented, enabled event bit sets the matching status bit on the next clock edge. The bit then stays set until software clears it.
- R3: A bus write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Only implemented bits can be set; all other bits read zero. MAC implemented bits are 0–19 and 24. Buffer ECC status uses four groups of four bits, in the order transmit (0–3), receive (4–7), schedule table (8–11), parser (12–15). Within each group, offset +0 is correctable, +1 is address mismatch, +2 is uncorrectable and +3 is reserved. DMA ECC status uses bits 0 (correctable), 1 (address mismatch) and 2 (uncorrectable).
- R6: Protection level (address 5, bits 1:0) gates capture. Level 0 captures nothing. Level 1 captures buffer and DMA ECC only. Level 2 adds every MAC bit except the external-port parity bits 0 and 5. Level 3 adds bits 0 and 5.
- R7: The summary word (address 3) has these bits: bit0 = any MAC status bit; bit1 = any buffer correctable bit; bit2 = any buffer address-mismatch or uncorrectable bit; bit3 = DMA correctable; bit4 = DMA address-mismatch or uncorrectable. Each flag clears by itself once its status bits are cleared.
- R8: A correctable status bit drives `irq` only while its enable is set. The enables sit at address 4: bit0 transmit, bit1 receive, bit2 schedule table, bit3 parser, bit4 DMA segmentation.
- R9: Any MAC status bit, and any address-mismatch or uncorrectable bit, drives `irq` regardless of the enables.
- R10: Writes to the summary word have no effect.
- R11: The enable and level registers read back what was written in their defined bits; all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_evt | input | 32 | MAC parity/timeout event pulses |
| buf_evt | input | 32 | Buffer memory ECC event pulses |
| dma_evt | input | 32 | DMA memory ECC event pulses |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq | output | 1 | Safety interrupt |

## Verification
The bench targets three cases: a clearing write that coincides with a new pulse on the same bit, event pulses on reserved and unimplemented bits, and a level change with pulses already pending. A design that gives the clear priority over the new pulse silently loses an error. One that ignores the bit mask shows ghost status bits in the reserved group slots. The bench also separates address-mismatch bits from correctable ones. A design that treats them as correctable lets them be masked by the enables and leaves `irq` low. Finally, it checks that writes to the summary word and zero bits in a clearing write leave state untouched.

// File: rtl/safety_err_collector.sv
module safety_err_collector #(
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter int NGRP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mac_evt,
  input  logic [DW-1:0] buf_evt,
  input  logic [DW-1:0] dma_evt,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NEN = NGRP + 1;
  localparam logic [AW-1:0] A_MAC = 3'd0;
  localparam logic [AW-1:0] A_BUF = 3'd1;
  localparam logic [AW-1:0] A_DMA = 3'd2;
  localparam logic [AW-1:0] A_SUM = 3'd3;
  localparam logic [AW-1:0] A_EN  = 3'd4;
  localparam logic [AW-1:0] A_LVL = 3'd5;
  localparam logic [DW-1:0] MAC_CORE = DW'(32'h010F_FFDE);
  localparam logic [DW-1:0] MAC_EXT  = DW'(32'h0000_0021);
  localparam logic [DW-1:0] DMA_IMPL = DW'(3'b111);

  logic [DW-1:0]   mac_q, buf_q, dma_q;
  logic [NEN-1:0]  en_q;
  logic [1:0]      lvl_q;
  logic [DW-1:0]   mac_allow, buf_allow, dma_allow;
  logic [NGRP-1:0] grp_corr, grp_unc;
  logic [4:0]      summary;
  logic            wr;

  assign wr = bus_sel & bus_wr;

  always_comb begin
    buf_allow = '0;
    for (int g = 0; g < NGRP; g++) begin
      buf_allow[4*g +: 3] = {3{lvl_q != 2'd0}};
      grp_corr[g] = buf_q[4*g];
      grp_unc[g]  = buf_q[4*g+1] | buf_q[4*g+2];
    end
  end

  assign mac_allow = (lvl_q >= 2'd2 ? MAC_CORE : '0) | (lvl_q == 2'd3 ? MAC_EXT : '0);
  assign dma_allow = (lvl_q != 2'd0) ? DMA_IMPL : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mac_q <= '0;
      buf_q <= '0;
      dma_q <= '0;
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      mac_q <= (mac_q & ~((wr && bus_addr == A_MAC) ? bus_wdata : '0)) | (mac_evt & mac_allow);
      buf_q <= (buf_q & ~((wr && bus_addr == A_BUF) ? bus_wdata : '0)) | (buf_evt & buf_allow);
      dma_q <= (dma_q & ~((wr && bus_addr == A_DMA) ? bus_wdata : '0)) | (dma_evt & dma_allow);
      if (wr && bus_addr == A_EN)  en_q  <= bus_wdata[NEN-1:0];
      if (wr && bus_addr == A_LVL) lvl_q <= bus_wdata[1:0];
    end
  end

  assign summary = {|dma_q[2:1], dma_q[0], |grp_unc, |grp_corr, |mac_q};

  assign irq = summary[0] | summary[2] | summary[4] | |({dma_q[0], grp_corr} & en_q);

  always_comb begin
    case (bus_addr)
      A_MAC:   bus_rdata = mac_q;
      A_BUF:   bus_rdata = buf_q;
      A_DMA:   bus_rdata = dma_q;
      A_SUM:   bus_rdata = DW'(summary);
      A_EN:    bus_rdata = DW'(en_q);
      A_LVL:   bus_rdata = DW'(lvl_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module safety_err_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] mac_evt,
  input logic [31:0] buf_evt,
  input logic [31:0] mac_q,
  input logic [31:0] buf_q,
  input logic [31:0] dma_q,
  input logic [1:0]  lvl_q,
  input logic        irq
);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd0 && bus_wdata[3] && mac_evt[3] && lvl_q >= 2'd2) |=> mac_q[3]);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd1 && bus_wdata[0] && !buf_evt[0]) |=> !buf_q[0]);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_q[4] && !(bus_sel && bus_wr && bus_addr == 3'd1 && bus_wdata[4])) |=> buf_q[4]);
  // R9
  uncorr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q[2:1] != 2'b00 || mac_q != 32'd0) |-> irq);
  // R6
  level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == 2'd0 && mac_q == 32'd0 && buf_q == 32'd0 && dma_q == 32'd0)
      |=> (mac_q == 32'd0 && buf_q == 32'd0 && dma_q == 32'd0));
endmodule

bind safety_err_collector safety_err_collector_chk chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mac_evt(mac_evt), .buf_evt(buf_evt), .mac_q(mac_q),
  .buf_q(buf_q), .dma_q(dma_q), .lvl_q(lvl_q), .irq(irq)
);

// File: tb/safety_err_collector_test.sv
`timescale 1ns/1ps
module safety_err_collector_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] mac_evt = 0, buf_evt = 0, dma_evt = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_st [3];
  logic [4:0]  m_en;
  logic [1:0]  m_lvl;

  always #4 clk = ~clk;

  safety_err_collector uut (.*);

  function automatic logic [31:0] allowed(int src, int lvl);
    logic [31:0] r = 0;
    for (int b = 0; b < 32; b++) begin
      if (src == 0) r[b] = (b <= 19 || b == 24) && (lvl == 3 || (lvl == 2 && b != 0 && b != 5));
      else if (src == 1) r[b] = (b < 16) && (b % 4 != 3) && lvl >= 1;
      else r[b] = (b < 3) && lvl >= 1;
    end
    return r;
  endfunction

  function automatic logic [4:0] m_sum();
    logic [4:0] s = 0;
    s[0] = m_st[0] != 0;
    for (int g = 0; g < 4; g++) begin
      if (m_st[1][4*g]) s[1] = 1;
      if (m_st[1][4*g+1] || m_st[1][4*g+2]) s[2] = 1;
    end
    s[3] = m_st[2][0];
    s[4] = m_st[2][1] || m_st[2][2];
    return s;
  endfunction

  function automatic logic m_irq();
    logic [4:0] s = m_sum();
    logic r = s[0] || s[2] || s[4];
    for (int g = 0; g < 4; g++) if (m_en[g] && m_st[1][4*g]) r = 1;
    if (m_en[4] && m_st[2][0]) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      0, 1, 2: return m_st[a];
      3: return {27'd0, m_sum()};
      4: return {27'd0, m_en};
      5: return {30'd0, m_lvl};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one clock with current inputs, update the model, compare irq.
  task automatic step(string tag);
    logic [31:0] ev [3];
    logic [31:0] clr [3];
    logic [31:0] n [3];
    ev[0] = mac_evt; ev[1] = buf_evt; ev[2] = dma_evt;
    for (int s = 0; s < 3; s++) begin
      clr[s] = (bus_sel && bus_wr && bus_addr == s) ? bus_wdata : 0;
      n[s] = rst_n ? ((m_st[s] & ~clr[s]) | (ev[s] & allowed(s, m_lvl))) : 0;
    end
    @(posedge clk);
    if (!rst_n) begin
      m_en = 0; m_lvl = 0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 4) m_en = bus_wdata[4:0];
      if (bus_sel && bus_wr && bus_addr == 5) m_lvl = bus_wdata[1:0];
    end
    for (int s = 0; s < 3; s++) m_st[s] = n[s];
    @(negedge clk);
    mac_evt = 0; buf_evt = 0; dma_evt = 0; bus_sel = 0; bus_wr = 0;
    chk(tag, {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = d;
    step(tag);
  endtask

  task automatic rd(int a, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'(a);
    #1;
    chk(tag, bus_rdata, m_read(a));
    bus_sel = 0;
  endtask

  task automatic pulse(logic [31:0] m, logic [31:0] b, logic [31:0] d, string tag);
    mac_evt = m; buf_evt = b; dma_evt = d;
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++) m_st[s] = 0;
    m_en = 0; m_lvl = 0;
    @(negedge clk);
    step("R1 reset"); step("R1 reset");
    rst_n = 1;
    for (int a = 0; a < 6; a++) rd(a, "R1 reset value");
    chk("R1 irq", {31'd0, irq}, 32'd0);

    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFF, "R6 level0");
    for (int a = 0; a < 3; a++) rd(a, "R6 level0 capture");

    wr(5, 32'hFFFF_FFFD, "R11 level write");
    rd(5, "R11 level readback");
    wr(4, 32'hFFFF_FFE0, "R11 enable write");
    rd(4, "R11 enable unused bits");

    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 level1");
    rd(0, "R6 level1 no MAC");
    rd(1, "R5 buffer mask");
    rd(2, "R5 dma mask");
    rd(3, "R7 summary");
    chk("R9 irq uncorr", {31'd0, irq}, 32'd1);

    wr(1, 32'h6666, "R3 clear uncorr");
    wr(2, 32'h6, "R3 clear dma");
    rd(1, "R3 partial clear");
    rd(3, "R7 auto clear");
    chk("R8 masked", {31'd0, irq}, 32'd0);
    wr(4, 32'h4, "R8 sched enable");
    chk("R8 sched irq", {31'd0, irq}, 32'd1);
    wr(1, 32'h0, "R3 zero write");
    rd(1, "R3 zero write no effect");
    wr(1, 32'h0100, "R8 clear sched");
    chk("R8 sched gone", {31'd0, irq}, 32'd0);
    wr(4, 32'h10, "R8 dma enable");
    chk("R8 dma irq", {31'd0, irq}, 32'd1);
    wr(3, 32'hFFFF_FFFF, "R10 summary write");
    rd(3, "R10 summary unchanged");
    rd(2, "R10 status unchanged");

    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h1; buf_evt = 32'h1;
    step("R4 set wins");
    rd(1, "R4 set wins");

    wr(5, 2, "R6 level2");
    pulse(32'hFFFF_FFFF, 0, 0, "R6 level2 mac");
    rd(0, "R6 level2 mac bits");
    chk("R9 mac irq", {31'd0, irq}, 32'd1);
    wr(5, 3, "R6 level3");
    pulse(32'h21, 0, 0, "R6 level3 ext");
    rd(0, "R6 level3 ext bits");
    wr(0, 32'hFFFF_FFFF, "R3 mac clear");
    rd(3, "R7 mac flag cleared");
    pulse(32'h0200_0000, 32'h8888, 32'h8, "R5 reserved");
    rd(0, "R5 mac reserved");
    rd(1, "R5 buf reserved");

    pulse(0, 32'h0020, 0, "R9 addr mismatch");
    wr(4, 0, "R9 enables off");
    chk("R9 mismatch irq", {31'd0, irq}, 32'd1);
    rd(2, "R2 sticky dma");

    for (int i = 0; i < 400; i++) begin
      mac_evt = $urandom; buf_evt = $urandom & $urandom; dma_evt = $urandom;
      if ($urandom_range(0, 2) == 0) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 3'($urandom_range(0, 6)); bus_wdata = $urandom;
      end
      step("R2 random irq");
      rd($urandom_range(0, 6), "R2 random read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule